// File: doc/BRIEF.md
# Mailbox channel window bank

A one-way hardware mailbox built from a parameterised number of 32-bit channel windows. Each window is visible through two register frames on separate word-addressed register buses. The transmit frame can only OR bits into a window's status word. The receive frame can only clear those bits, and it holds a per-window mask that decides which bits raise its interrupt. A window's address slot is 0x20 bytes wide, so window `w` decodes at `w*0x20` in both frames. A control region from 0xF80 upward holds configuration, identification, a frame-level interrupt enable, an access request/ready handshake and four summary words with one bit per window.

The receive interrupt is a level: it stays high while any window holds a set bit that is not masked. When the architecture minor revision is nonzero, each window also reports completion to the transmit side. A completion is flagged when the receiver empties a status word that the sender had filled. The flagged windows that are enabled are gathered into the transmit interrupt, which is gated by a frame-level enable. Reads return data one cycle after the request.

Top module: `mbx_window_bank`

## Requirements
- R1: After reset every status word is 0 and every receive mask word is 0xFFFFFFFF. Both interrupts are low, and reading the status at slot offset 0x00 or the masked status at 0x04 returns 0.
- R2: A transmit write to window offset 0x0C ORs the write data into that window's status. Both frames read the status at window offset 0x00.
- R3: A receive write to window offset 0x08 clears each status bit written as 1. When the transmit frame sets a bit in the same cycle that the receive frame clears it, the bit ends up set.
- R4: In the receive frame, offset 0x10 reads the mask, 0x14 ORs the write data into the mask, 0x18 clears the mask bits written as 1, and 0x04 reads status AND NOT mask.
- R5: rx_irq_o is high exactly while some window has a status bit set whose mask bit is 0. It is low in the cycle that follows the write that clears or masks the last such bit.
- R6: With minor revision nonzero, a window's completion flag (transmit offset 0x10, bit 0) is set when its status goes from nonzero to zero. Writing 1 to bit 0 at offset 0x14 clears the flag. Offset 0x18 bit 0 is the window's enable. A set flag whose window is not enabled does not drive tx_irq_o.
- R7: Transmit register 0xF98 bit 2 is the frame enable. tx_irq_o equals that enable ANDed with "some window has both its completion flag and its enable set". Transmit 0xF90 bit 2 reads that pending condition.
- R8: Summary words at 0xFA0, 0xFA4, 0xFA8 and 0xFAC report window w in word w/32, bit w%32. In the transmit frame the bit is flag AND enable. In the receive frame the bit means the window has an unmasked set bit.
- R9: 0xF80 reads NUM_WIN in bits [6:0]. 0xFCC reads the minor revision in bits [3:0] and the major revision in bits [7:4]. Both values appear in both frames.
- R10: Transmit 0xF88 bit 0 is the access request (read/write). The ready flag at 0xF8C bit 0 becomes set at the second clock edge after the edge that accepts a write of 1, so three back-to-back reads issued right after that write return 0, 0, 1. Ready reads 0 from the cycle after request is written 0.
- R11: Windows at or beyond NUM_WIN, unused slot offsets, unlisted control offsets and misaligned addresses read as 0. Writes to them, and writes to read-only offsets, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_req_i | input | 1 | Transmit frame access strobe |
| tx_we_i | input | 1 | Transmit frame write enable |
| tx_addr_i | input | 12 | Transmit frame byte address |
| tx_wdata_i | input | 32 | Transmit frame write data |
| tx_rdata_o | output | 32 | Transmit frame read data, one cycle after a read |
| rx_req_i | input | 1 | Receive frame access strobe |
| rx_we_i | input | 1 | Receive frame write enable |
| rx_addr_i | input | 12 | Receive frame byte address |
| rx_wdata_i | input | 32 | Receive frame write data |
| rx_rdata_o | output | 32 | Receive frame read data, one cycle after a read |
| rx_irq_o | output | 1 | Receive interrupt level |
| tx_irq_o | output | 1 | Transmit completion interrupt level |

## Verification
The hardest state to reach is a transmit completion. It needs a transmit set, then a receive clear that empties the whole word, with the window enable and the frame enable arranged beforehand. The stimulus raises one completion with both enables on and another with the window enable off, which checks the gating. It also drives both frames in the same cycle against the same bits, which exercises the set-over-clear collision that neither bus alone can produce.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned ADDR_W     = 12;
  localparam int unsigned SLOT_WORDS = 8;
  localparam int unsigned CTL_WORDS  = 32;
  localparam int unsigned COMB_REGS  = 4;
  localparam logic [4:0]  CTL_TAG    = 5'h1F;  // addr[11:7] of 0xF80..0xFFF

  // word index inside a 0x20 window slot (addr[4:2])
  localparam logic [2:0] SW_STAT   = 3'd0;
  localparam logic [2:0] SW_MASKED = 3'd1;
  localparam logic [2:0] SW_CLR    = 3'd2;
  localparam logic [2:0] SW_SET    = 3'd3;
  localparam logic [2:0] SW_FLAG   = 3'd4;
  localparam logic [2:0] SW_FCLR   = 3'd5;
  localparam logic [2:0] SW_FEN    = 3'd6;
  localparam logic [2:0] SW_MASK   = 3'd4;
  localparam logic [2:0] SW_MSET   = 3'd5;
  localparam logic [2:0] SW_MCLR   = 3'd6;

  // word index inside the control region (addr[6:2])
  localparam logic [4:0] CW_CFG     = 5'd0;
  localparam logic [4:0] CW_ACC_REQ = 5'd2;
  localparam logic [4:0] CW_ACC_RDY = 5'd3;
  localparam logic [4:0] CW_FIRQ_ST = 5'd4;
  localparam logic [4:0] CW_FIRQ_EN = 5'd6;
  localparam logic [4:0] CW_COMB0   = 5'd8;
  localparam logic [4:0] CW_ARCH    = 5'd19;
  localparam int unsigned FIRQ_COMB_BIT = 2;
endpackage

// File: rtl/mbx_win.sv
module mbx_win import mbx_pkg::*; #(
  parameter bit HAS_TXIRQ = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [WORD_W-1:0] set_val_i,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] clr_val_i,
  input  logic              mset_i,
  input  logic              mclr_i,
  input  logic [WORD_W-1:0] mval_i,
  input  logic              fclr_i,
  input  logic              fen_we_i,
  input  logic              fen_val_i,
  output logic [WORD_W-1:0] stat_o,
  output logic [WORD_W-1:0] mask_o,
  output logic              flag_o,
  output logic              fen_o
);
  logic [WORD_W-1:0] stat_q, stat_d, mask_q, mask_d;
  logic fen_q;

  always_comb begin
    stat_d = stat_q;
    if (clr_i) stat_d = stat_d & ~clr_val_i;
    if (set_i) stat_d = stat_d | set_val_i;  // set wins over a same-cycle clear
    mask_d = mask_q;
    if (mset_i) mask_d = mask_d | mval_i;
    if (mclr_i) mask_d = mask_d & ~mval_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
      fen_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      if (fen_we_i) fen_q <= fen_val_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign fen_o  = fen_q;

  if (HAS_TXIRQ) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else flag_q <= (flag_q & ~fclr_i) | ((stat_q != '0) && (stat_d == '0));
    end
    assign flag_o = flag_q;

    a_r6_flag_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o) |-> (stat_o == '0) && ($past(stat_o) != '0));
  end else begin : g_noflag
    assign flag_o = 1'b0;
  end

  a_r2_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((stat_o & $past(set_val_i)) == $past(set_val_i)));
  a_r3_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((stat_o & $past(clr_val_i)) == '0));
  a_r4_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mset_i && !mclr_i) |=> ((mask_o & $past(mval_i)) == $past(mval_i)));
endmodule

// File: rtl/mbx_access.sv
module mbx_access (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic val_i,
  output logic req_o,
  output logic rdy_o
);
  logic req_q, stg_q, rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      stg_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      if (we_i) req_q <= val_i;
      stg_q <= req_q;
      rdy_q <= stg_q & req_q;
    end
  end

  assign req_o = req_q;
  assign rdy_o = rdy_q & req_q;  // drops with the request, no lag

  a_r10_rdy_after_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> ($past(req_o) && $past(req_o, 2)));
  a_r10_rdy_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !val_i) |=> !rdy_o);
endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux import mbx_pkg::*; #(
  parameter int unsigned NUM_WIN = 4
) (
  input  logic [ADDR_W-1:0]                             addr_i,
  input  logic [NUM_WIN-1:0][SLOT_WORDS-1:0][WORD_W-1:0] slot_i,
  input  logic [CTL_WORDS-1:0][WORD_W-1:0]               ctl_i,
  output logic [WORD_W-1:0]                              rdata_o
);
  localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  logic [6:0] idx;
  assign idx = addr_i[11:5];

  always_comb begin
    rdata_o = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i[11:7] == CTL_TAG) rdata_o = ctl_i[addr_i[6:2]];
      else if (idx < 7'(NUM_WIN)) rdata_o = slot_i[idx[IDX_W-1:0]][addr_i[4:2]];
    end
  end
endmodule

// File: rtl/mbx_window_bank.sv
module mbx_window_bank import mbx_pkg::*; #(
  parameter int unsigned NUM_WIN    = 4,
  parameter int unsigned ARCH_MINOR = 1,
  parameter int unsigned ARCH_MAJOR = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_req_i,
  input  logic        tx_we_i,
  input  logic [11:0] tx_addr_i,
  input  logic [31:0] tx_wdata_i,
  output logic [31:0] tx_rdata_o,
  input  logic        rx_req_i,
  input  logic        rx_we_i,
  input  logic [11:0] rx_addr_i,
  input  logic [31:0] rx_wdata_i,
  output logic [31:0] rx_rdata_o,
  output logic        rx_irq_o,
  output logic        tx_irq_o
);
  localparam bit          HAS_TXIRQ = (ARCH_MINOR != 0);
  localparam int unsigned COMB_W    = COMB_REGS * WORD_W;
  localparam logic [WORD_W-1:0] CFG_WORD  = WORD_W'(7'(NUM_WIN));
  localparam logic [WORD_W-1:0] ARCH_WORD = WORD_W'({4'(ARCH_MAJOR), 4'(ARCH_MINOR)});

  logic [NUM_WIN-1:0][WORD_W-1:0] stat, mask;
  logic [NUM_WIN-1:0] flag, fen, scomb, rcomb;
  logic [COMB_W-1:0]  scomb_w, rcomb_w;
  logic tx_wr, rx_wr, tx_ctl, acc_req, acc_rdy, firq_en_q, tx_pend;
  logic [NUM_WIN-1:0][SLOT_WORDS-1:0][WORD_W-1:0] tx_slot, rx_slot;
  logic [CTL_WORDS-1:0][WORD_W-1:0] tx_ctlw, rx_ctlw;
  logic [WORD_W-1:0] tx_mux, rx_mux, tx_rdata_q, rx_rdata_q;

  assign tx_wr  = tx_req_i && tx_we_i && (tx_addr_i[1:0] == 2'b00);
  assign rx_wr  = rx_req_i && rx_we_i && (rx_addr_i[1:0] == 2'b00);
  assign tx_ctl = tx_addr_i[11:7] == CTL_TAG;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic tx_sel, rx_sel;
    assign tx_sel = tx_wr && (tx_addr_i[11:5] == 7'(w));
    assign rx_sel = rx_wr && (rx_addr_i[11:5] == 7'(w));

    mbx_win #(.HAS_TXIRQ(HAS_TXIRQ)) u_win (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (tx_sel && (tx_addr_i[4:2] == SW_SET)),
      .set_val_i (tx_wdata_i),
      .clr_i     (rx_sel && (rx_addr_i[4:2] == SW_CLR)),
      .clr_val_i (rx_wdata_i),
      .mset_i    (rx_sel && (rx_addr_i[4:2] == SW_MSET)),
      .mclr_i    (rx_sel && (rx_addr_i[4:2] == SW_MCLR)),
      .mval_i    (rx_wdata_i),
      .fclr_i    (tx_sel && (tx_addr_i[4:2] == SW_FCLR) && tx_wdata_i[0]),
      .fen_we_i  (tx_sel && (tx_addr_i[4:2] == SW_FEN)),
      .fen_val_i (tx_wdata_i[0]),
      .stat_o    (stat[w]),
      .mask_o    (mask[w]),
      .flag_o    (flag[w]),
      .fen_o     (fen[w])
    );

    assign scomb[w] = flag[w] & fen[w];
    assign rcomb[w] = |(stat[w] & ~mask[w]);
  end

  assign scomb_w = COMB_W'(scomb);
  assign rcomb_w = COMB_W'(rcomb);

  mbx_access u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tx_wr && tx_ctl && (tx_addr_i[6:2] == CW_ACC_REQ)),
    .val_i  (tx_wdata_i[0]),
    .req_o  (acc_req),
    .rdy_o  (acc_rdy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) firq_en_q <= 1'b0;
    else if (tx_wr && tx_ctl && (tx_addr_i[6:2] == CW_FIRQ_EN))
      firq_en_q <= tx_wdata_i[FIRQ_COMB_BIT];
  end

  assign tx_pend  = |scomb;
  assign tx_irq_o = firq_en_q & tx_pend;
  assign rx_irq_o = |rcomb;

  always_comb begin
    tx_slot = '0;
    rx_slot = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      tx_slot[w][SW_STAT]   = stat[w];
      tx_slot[w][SW_FLAG]   = WORD_W'(flag[w]);
      tx_slot[w][SW_FEN]    = WORD_W'(fen[w]);
      rx_slot[w][SW_STAT]   = stat[w];
      rx_slot[w][SW_MASKED] = stat[w] & ~mask[w];
      rx_slot[w][SW_MASK]   = mask[w];
    end
    tx_ctlw = '0;
    rx_ctlw = '0;
    tx_ctlw[CW_CFG]     = CFG_WORD;
    rx_ctlw[CW_CFG]     = CFG_WORD;
    tx_ctlw[CW_ARCH]    = ARCH_WORD;
    rx_ctlw[CW_ARCH]    = ARCH_WORD;
    tx_ctlw[CW_ACC_REQ] = WORD_W'(acc_req);
    tx_ctlw[CW_ACC_RDY] = WORD_W'(acc_rdy);
    tx_ctlw[CW_FIRQ_ST][FIRQ_COMB_BIT] = tx_pend;
    tx_ctlw[CW_FIRQ_EN][FIRQ_COMB_BIT] = firq_en_q;
    for (int k = 0; k < COMB_REGS; k++) begin
      tx_ctlw[CW_COMB0 + 5'(k)] = scomb_w[k*WORD_W +: WORD_W];
      rx_ctlw[CW_COMB0 + 5'(k)] = rcomb_w[k*WORD_W +: WORD_W];
    end
  end

  mbx_rdmux #(.NUM_WIN(NUM_WIN)) u_tx_mux (
    .addr_i (tx_addr_i), .slot_i (tx_slot), .ctl_i (tx_ctlw), .rdata_o (tx_mux)
  );
  mbx_rdmux #(.NUM_WIN(NUM_WIN)) u_rx_mux (
    .addr_i (rx_addr_i), .slot_i (rx_slot), .ctl_i (rx_ctlw), .rdata_o (rx_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_rdata_q <= '0;
      rx_rdata_q <= '0;
    end else begin
      if (tx_req_i && !tx_we_i) tx_rdata_q <= tx_mux;
      if (rx_req_i && !rx_we_i) rx_rdata_q <= rx_mux;
    end
  end

  assign tx_rdata_o = tx_rdata_q;
  assign rx_rdata_o = rx_rdata_q;

  a_r5_rxirq_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_irq_o) |-> $past(rx_req_i && rx_we_i));
  a_r7_txirq_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_irq_o) |-> $past((rx_req_i && rx_we_i) || (tx_req_i && tx_we_i)));
  a_r11_misaligned_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_i && !tx_we_i && (tx_addr_i[1:0] != 2'b00)) |=> (tx_rdata_o == '0));
endmodule

// File: tb/sim_mbx_window_bank.sv
module sim_mbx_window_bank;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tx_req = 0, tx_we = 0, rx_req = 0, rx_we = 0;
  logic [11:0] tx_addr = '0, rx_addr = '0;
  logic [31:0] tx_wdata = '0, rx_wdata = '0;
  logic [31:0] tx_rdata, rx_rdata;
  logic rx_irq, tx_irq;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbx_window_bank #(.NUM_WIN(4), .ARCH_MINOR(1), .ARCH_MAJOR(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_req_i(tx_req), .tx_we_i(tx_we), .tx_addr_i(tx_addr), .tx_wdata_i(tx_wdata), .tx_rdata_o(tx_rdata),
    .rx_req_i(rx_req), .rx_we_i(rx_we), .rx_addr_i(rx_addr), .rx_wdata_i(rx_wdata), .rx_rdata_o(rx_rdata),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  typedef struct packed {
    logic        rx;
    logic        we;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 12'h010, 32'h0, 32'hFFFF_FFFF, 4'd1},  // R1 mask reset
    '{1'b0, 1'b0, 12'h000, 32'h0, 32'h0,         4'd1},  // R1
    '{1'b1, 1'b0, 12'h004, 32'h0, 32'h0,         4'd1},  // R1
    '{1'b0, 1'b0, 12'hF80, 32'h0, 32'h4,         4'd9},  // R9
    '{1'b1, 1'b0, 12'hF80, 32'h0, 32'h4,         4'd9},  // R9
    '{1'b1, 1'b0, 12'hFCC, 32'h0, 32'h21,        4'd9},  // R9
    '{1'b0, 1'b0, 12'hFCC, 32'h0, 32'h21,        4'd9},  // R9
    '{1'b0, 1'b1, 12'h00C, 32'hF0, 32'h0,        4'd2},
    '{1'b0, 1'b1, 12'h00C, 32'h03, 32'h0,        4'd2},
    '{1'b0, 1'b0, 12'h000, 32'h0, 32'hF3,        4'd2},  // R2 OR accumulate
    '{1'b1, 1'b0, 12'h000, 32'h0, 32'hF3,        4'd2},  // R2
    '{1'b1, 1'b0, 12'h004, 32'h0, 32'h0,         4'd4},  // R4 all masked
    '{1'b1, 1'b1, 12'h018, 32'hF, 32'h0,         4'd4},
    '{1'b1, 1'b0, 12'h010, 32'h0, 32'hFFFF_FFF0, 4'd4},  // R4
    '{1'b1, 1'b0, 12'h004, 32'h0, 32'h3,         4'd4},  // R4
    '{1'b1, 1'b0, 12'hFA0, 32'h0, 32'h1,         4'd8},  // R8
    '{1'b1, 1'b1, 12'h014, 32'h1, 32'h0,         4'd4},
    '{1'b1, 1'b0, 12'h004, 32'h0, 32'h2,         4'd4},  // R4
    '{1'b1, 1'b1, 12'h008, 32'h30, 32'h0,        4'd3},
    '{1'b1, 1'b0, 12'h000, 32'h0, 32'hC3,        4'd3},  // R3
    '{1'b0, 1'b1, 12'h04C, 32'h8000_0000, 32'h0, 4'd2},
    '{1'b0, 1'b0, 12'h040, 32'h0, 32'h8000_0000, 4'd2},  // R2 window 2
    '{1'b1, 1'b0, 12'hFA0, 32'h0, 32'h1,         4'd8},  // R8
    '{1'b0, 1'b1, 12'h0AC, 32'h1, 32'h0,         4'd11},
    '{1'b0, 1'b0, 12'h0A0, 32'h0, 32'h0,         4'd11}, // R11 beyond NUM_WIN
    '{1'b0, 1'b0, 12'h008, 32'h0, 32'h0,         4'd11}, // R11 unused offset
    '{1'b0, 1'b1, 12'h000, 32'hFFFF, 32'h0,      4'd11},
    '{1'b0, 1'b0, 12'h000, 32'h0, 32'hC3,        4'd11}, // R11 read-only
    '{1'b1, 1'b0, 12'hF84, 32'h0, 32'h0,         4'd11}, // R11
    '{1'b1, 1'b0, 12'h002, 32'h0, 32'h0,         4'd11}  // R11 misaligned
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit rx, input logic [11:0] a, input logic [31:0] d);
    if (rx) begin rx_req = 1; rx_we = 1; rx_addr = a; rx_wdata = d; end
    else    begin tx_req = 1; tx_we = 1; tx_addr = a; tx_wdata = d; end
    @(negedge clk);
    tx_req = 0; tx_we = 0; rx_req = 0; rx_we = 0;
  endtask

  task automatic rd(input bit rx, input logic [11:0] a, output logic [31:0] d);
    if (rx) begin rx_req = 1; rx_we = 0; rx_addr = a; end
    else    begin tx_req = 1; tx_we = 0; tx_addr = a; end
    @(negedge clk);
    tx_req = 0; rx_req = 0;
    d = rx ? rx_rdata : tx_rdata;
  endtask

  task automatic rdchk(input bit rx, input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(rx, a, v);
    check(tag, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      n_chk++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 rx_irq", 32'(rx_irq), 32'h0);
    check("R1 tx_irq", 32'(tx_irq), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].we) wr(TBL[i].rx, TBL[i].addr, TBL[i].wdata);
      else begin
        rd(TBL[i].rx, TBL[i].addr, v);
        check($sformatf("R%0d vec%0d", TBL[i].req, i), v, TBL[i].exp);
      end
    end

    // R5: w0 stat C3, mask FFFFFFF1 -> bit1 unmasked
    check("R5 irq high", 32'(rx_irq), 32'h1);
    wr(1, 12'h008, 32'h2);
    check("R5 irq falls on clear", 32'(rx_irq), 32'h0);
    wr(1, 12'h058, 32'h8000_0000);
    check("R5 irq on unmask", 32'(rx_irq), 32'h1);
    rdchk(1, 12'hFA0, 32'h4, "R8 rx summary w2");
    rdchk(1, 12'h044, 32'h8000_0000, "R4 masked w2");
    wr(1, 12'h054, 32'h8000_0000);
    check("R5 irq falls on mask", 32'(rx_irq), 32'h0);

    // R6/R7 completion with both enables
    wr(0, 12'h018, 32'h1);
    wr(0, 12'hF98, 32'h4);
    rdchk(0, 12'hF98, 32'h4, "R7 frame enable");
    check("R7 no pending", 32'(tx_irq), 32'h0);
    wr(1, 12'h008, 32'hFFFF_FFFF);
    check("R7 tx_irq on empty", 32'(tx_irq), 32'h1);
    rdchk(0, 12'h010, 32'h1, "R6 flag set");
    rdchk(0, 12'hFA0, 32'h1, "R8 tx summary");
    rdchk(0, 12'hF90, 32'h4, "R7 frame status");
    wr(0, 12'h014, 32'h1);
    check("R6 clear drops irq", 32'(tx_irq), 32'h0);
    rdchk(0, 12'h010, 32'h0, "R6 flag cleared");

    // R6 window enable off
    wr(1, 12'h048, 32'h8000_0000);
    check("R6 disabled window no irq", 32'(tx_irq), 32'h0);
    rdchk(0, 12'h050, 32'h1, "R6 flag w2");
    rdchk(0, 12'hFA0, 32'h0, "R8 tx summary gated");
    wr(0, 12'h054, 32'h1);

    // R3 same-cycle set and clear
    tx_req = 1; tx_we = 1; tx_addr = 12'h00C; tx_wdata = 32'h5;
    rx_req = 1; rx_we = 1; rx_addr = 12'h008; rx_wdata = 32'h5;
    @(negedge clk);
    tx_req = 0; tx_we = 0; rx_req = 0; rx_we = 0;
    rdchk(1, 12'h000, 32'h5, "R3 set wins");
    rdchk(0, 12'h010, 32'h0, "R6 no flag on fill");

    // R10 handshake
    wr(0, 12'hF88, 32'h1);
    rdchk(0, 12'hF8C, 32'h0, "R10 ready 1st");
    rdchk(0, 12'hF8C, 32'h0, "R10 ready 2nd");
    rdchk(0, 12'hF8C, 32'h1, "R10 ready 3rd");
    rdchk(0, 12'hF88, 32'h1, "R10 request readback");
    wr(0, 12'hF88, 32'h0);
    rdchk(0, 12'hF8C, 32'h0, "R10 ready drops");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule